// File: doc/BRIEF.md
# Signed Fractional Word Multiplier

This block multiplies two 32-bit two's-complement words that are read as signed fractions. The full 64-bit signed product is formed over several cycles. The block returns one 32-bit half of that product, and a select input captured with the start request picks which half.

In high mode the upper half of the product is shifted left by one bit, so that the binary point of a fraction-times-fraction result stays where it belongs. In low mode the lower half of the signed product is returned unchanged. The multiply never overflows, so the block reports no overflow.

The sign of each operand is removed before the multiply. A shift-and-add loop then multiplies the two magnitudes, and the 64-bit product is negated afterwards when the two operand signs differ. When either operand is zero, the loop is skipped and the answer is available at once.

Top module: `frac_mul`

## Requirements
- R1: The result sign is the XOR of the operand sign bits (bit 31). The magnitudes are multiplied, and the 64-bit magnitude product is negated when that XOR is 1.
- R2: If either operand is zero when a start is accepted, `busy_o` stays low. In the next cycle `done_o` is 1 and `result_o` is 0.
- R3: With `hi_sel_i` = 1 at start, `result_o` equals bits 63:32 of the signed product shifted left by one. Bit 31 of that upper half is discarded and bit 0 of the result is 0.
- R4: With `hi_sel_i` = 0 at start, `result_o` equals bits 31:0 of the signed 64-bit product.
- R5: The magnitude of 0x80000000 is taken modulo 2^32, which gives 2^31. Products that involve the most negative word therefore match true signed multiplication.
- R6: A start with both operands nonzero raises `busy_o` in the next cycle. `busy_o` then stays high for exactly 32 cycles. `done_o` is 1 for the single cycle that follows, and in that cycle `busy_o` is 0.
- R7: A start asserted while `busy_o` is 1 is ignored. The operation in progress keeps its operands, select and timing.
- R8: After reset, `busy_o`, `done_o` and `result_o` are all 0. `result_o` changes only in a cycle where `done_o` is 1, and it is held until the next accepted operation completes.
- R9: Negation is two's complement over all 64 bits. The low half is negated, and a carry enters the inverted high half only when the negated low half is zero. For example, -2^16 times 2^16 gives high-mode result 0xFFFFFFFE and low-mode result 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiply; accepted only while idle |
| a_i | input | 32 | Accumulator operand |
| b_i | input | 32 | Memory operand |
| hi_sel_i | input | 1 | 1 selects the realigned high half, 0 the low half |
| busy_o | output | 1 | Magnitude loop running |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Selected product half, held between operations |

## Verification
Two kinds of event can fall in the same cycle. The first is a start arriving in the last busy cycle, the same edge on which the loop finishes. The second is a new start arriving in the cycle `done_o` is high, so that a finished result and a newly accepted operation share a cycle. The bench provokes both by timing start requests against its count of busy cycles. The first start must have no effect, and the second must launch a fresh 32-cycle run with its own operands. A behavioural model steps alongside the design on every clock, so any disagreement in `busy_o`, `done_o` or `result_o` around these collisions is reported.

// File: rtl/frac_mul_pkg.sv
package frac_mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/frac_mul_sign.sv
module frac_mul_sign #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_o,
  output logic         zero_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // magnitude modulo 2^W: the most negative word maps to itself
  assign mag_a_o = a_i[W-1] ? (~a_i + ONE) : a_i;
  assign mag_b_o = b_i[W-1] ? (~b_i + ONE) : b_i;
  assign neg_o   = a_i[W-1] ^ b_i[W-1];
  assign zero_o  = (a_i == '0) || (b_i == '0);
endmodule

// File: rtl/frac_mul_core.sv
module frac_mul_core #(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           run_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_nxt_o,
  output logic           last_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] prod_q;
  logic [CW-1:0]  cnt_q;
  logic [W:0]     sum;

  // one shift-and-add step: add multiplicand on LSB, shift right with carry
  always_comb begin
    sum        = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
    prod_nxt_o = {sum, prod_q[W-1:1]};
  end

  assign last_o = run_i && (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      prod_q  <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{W{1'b0}}, mplier_i};
      cnt_q   <= '0;
    end else if (run_i) begin
      prod_q  <= prod_nxt_o;
      cnt_q   <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/frac_mul_fix.sv
module frac_mul_fix #(
  parameter int unsigned W = 32
) (
  input  logic [2*W-1:0] prod_i,
  input  logic           neg_i,
  input  logic           hi_sel_i,
  output logic [W-1:0]   res_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] lo, hi, lo_n, hi_n, s_lo, s_hi;

  always_comb begin
    lo   = prod_i[W-1:0];
    hi   = prod_i[2*W-1:W];
    lo_n = ~lo + ONE;
    // carry into the upper half only when the negated low half wraps to zero
    hi_n = ~hi + ((lo_n == '0) ? ONE : '0);
    s_lo = neg_i ? lo_n : lo;
    s_hi = neg_i ? hi_n : hi;
    res_o = hi_sel_i ? {s_hi[W-2:0], 1'b0} : s_lo;
  end
endmodule

// File: rtl/frac_mul.sv
module frac_mul
  import frac_mul_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         hi_sel_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  mul_state_e     state_q;
  logic           neg_q, hi_q, done_q;
  logic [W-1:0]   res_q;

  logic [W-1:0]   mag_a, mag_b, fix_res;
  logic           neg, zero, accept, load, run, last;
  logic [2*W-1:0] prod_nxt;

  frac_mul_sign #(.W(W)) u_sign (
    .a_i     (a_i),
    .b_i     (b_i),
    .mag_a_o (mag_a),
    .mag_b_o (mag_b),
    .neg_o   (neg),
    .zero_o  (zero)
  );

  assign accept = start_i && (state_q == ST_IDLE);
  assign load   = accept && !zero;
  assign run    = (state_q == ST_RUN);

  frac_mul_core #(.W(W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .run_i      (run),
    .mcand_i    (mag_a),
    .mplier_i   (mag_b),
    .prod_nxt_o (prod_nxt),
    .last_o     (last)
  );

  frac_mul_fix #(.W(W)) u_fix (
    .prod_i   (prod_nxt),
    .neg_i    (neg_q),
    .hi_sel_i (hi_q),
    .res_o    (fix_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      neg_q   <= 1'b0;
      hi_q    <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else if (accept) begin
      neg_q <= neg;
      hi_q  <= hi_sel_i;
      if (zero) begin
        res_q  <= '0;
        done_q <= 1'b1;
      end else begin
        state_q <= ST_RUN;
        done_q  <= 1'b0;
      end
    end else if (last) begin
      res_q   <= fix_res;
      done_q  <= 1'b1;
      state_q <= ST_IDLE;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o   = run;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/frac_mul_chk.sv
module frac_mul_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o
);
  localparam int unsigned BW = $clog2(W) + 2;
  logic [BW-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt <= '0;
    else         busy_cnt <= busy_o ? busy_cnt + BW'(1) : '0;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o || !$past(busy_o)); // R6
  AST_BUSY_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R6
  AST_BUSY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt == BW'(W)) && done_o); // R6
  AST_ZERO_SHORTCUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (a_i == '0 || b_i == '0)) |=> done_o && !busy_o && result_o == '0); // R2
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o)); // R8
  AST_NO_BUSY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o)); // R6
endmodule

bind frac_mul frac_mul_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/tb_frac_mul.sv
`timescale 1ns/1ps
module tb_frac_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        hi_sel = 1'b0;
  logic        busy, done;
  logic [31:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  bit cmp_on = 0;
  string cur_tag = "R8";

  always #2 clk = ~clk;

  frac_mul dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a), .b_i(b),
    .hi_sel_i(hi_sel), .busy_o(busy), .done_o(done), .result_o(result)
  );

  function automatic logic [31:0] ref_mul(logic [31:0] x, logic [31:0] y, logic hs);
    longint p;
    logic [63:0] u;
    p = longint'($signed(x)) * longint'($signed(y));
    u = p;
    return hs ? {u[62:32], 1'b0} : u[31:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference, stepped every clock
  logic        m_busy, m_done;
  logic [31:0] m_res, m_pend;
  int          m_left;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_res <= 0; m_pend <= 0; m_left <= 0;
    end else if (!m_busy && start) begin
      if (a == 0 || b == 0) begin
        m_res <= 0; m_done <= 1;
      end else begin
        m_busy <= 1; m_left <= 32; m_done <= 0;
        m_pend <= ref_mul(a, b, hi_sel);
      end
    end else if (m_busy && m_left == 1) begin
      m_busy <= 0; m_done <= 1; m_res <= m_pend; m_left <= 0;
    end else begin
      m_done <= 0;
      if (m_busy) m_left <= m_left - 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n && !finished) begin
      check("R6 busy", {31'b0, busy}, {31'b0, m_busy});
      check("R6 done", {31'b0, done}, {31'b0, m_done});
      check(cur_tag, result, m_res);
    end
  end

  task automatic do_op(logic [31:0] x, logic [31:0] y, logic hs, string tag);
    int bcnt = 0;
    int guard = 0;
    cur_tag = tag;
    @(negedge clk);
    start = 1; a = x; b = y; hi_sel = hs;
    @(negedge clk);
    start = 0; a = 32'h5A5A_0F0F; b = 32'h1234_8765; hi_sel = ~hs;
    while (!done && guard < 100) begin
      if (busy) bcnt++;
      guard++;
      @(negedge clk);
    end
    check(tag, result, ref_mul(x, y, hs));
    check("R6 busy count", bcnt, (x == 0 || y == 0) ? 0 : 32);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    check("R8 reset busy", {31'b0, busy}, 32'd0);
    check("R8 reset done", {31'b0, done}, 32'd0);
    check("R8 reset result", result, 32'd0);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);

    do_op(32'h4000_0000, 32'h4000_0000, 1, "R3");
    do_op(32'h0000_0003, 32'h0000_0005, 0, "R4");
    do_op(32'hC000_0000, 32'h2000_0000, 1, "R1");
    do_op(32'hFFFF_FFFD, 32'h0000_0007, 0, "R1");
    do_op(32'hFFFF_FF00, 32'hFFFF_F000, 0, "R1");
    do_op(32'h9000_0001, 32'hA000_0003, 1, "R1");
    do_op(32'h0000_0000, 32'h1234_5678, 1, "R2");
    do_op(32'h8765_4321, 32'h0000_0000, 0, "R2");
    do_op(32'h8000_0000, 32'h8000_0000, 1, "R5");
    do_op(32'h8000_0000, 32'h0000_0001, 0, "R5");
    do_op(32'h8000_0000, 32'h0000_0001, 1, "R5");
    do_op(32'hFFFF_0000, 32'h0001_0000, 1, "R9");
    do_op(32'hFFFF_0000, 32'h0001_0000, 0, "R9");

    lf = 32'hACE1_1357;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] x, y;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      x = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      y = lf ^ 32'h3C3C_3C3C;
      do_op(x, y, i[0], i[0] ? "R3" : "R4");
    end

    // R7: start during busy, including on the final busy cycle
    cur_tag = "R7";
    @(negedge clk);
    start = 1; a = 32'h1111_1111; b = 32'h7000_0007; hi_sel = 1;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    start = 1; a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; hi_sel = 0;
    @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    start = 1; a = 32'h0000_0000; b = 32'h0000_0001; hi_sel = 0;
    @(negedge clk);
    start = 0;
    check("R7 done after ignored starts", {31'b0, done}, 32'd1);
    check("R7", result, ref_mul(32'h1111_1111, 32'h7000_0007, 1));
    // start in the done cycle is accepted
    start = 1; a = 32'hFFFF_FFFE; b = 32'h0000_0003; hi_sel = 0;
    @(negedge clk);
    start = 0;
    check("R6 busy after done-cycle start", {31'b0, busy}, 32'd1);
    while (!done) @(negedge clk);
    check("R6", result, 32'hFFFF_FFFA);

    // R8: result held while idle
    cur_tag = "R8";
    repeat (6) @(negedge clk);
    check("R8 held", result, 32'hFFFF_FFFA);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule